// File: doc/BRIEF.md
# Lane-Merging Word Memory with Burst Sequencer

This block is a word-organised 32-bit memory with a small sequencer in front of it. One request is taken at a time. A request is a memory read, a memory write of a byte, halfword or word, a coprocessor word write, or a slot flush. Each request carries a coprocessor-mode flag. Byte and halfword writes are done as a read-modify-write of the addressed word, so only the selected lanes change. Bytes outside those lanes keep their stored value.

In coprocessor mode the dispatch unit presents a set of word slots with the request. Each slot is either full, carrying a word, or empty. The length of a burst is set by the leading run of slots. A write stores the leading full slots at consecutive word addresses. A read fetches one word for each leading empty slot. Words read from memory, and words passed through from the coprocessor, leave the block on a read-data stream. Memory that has never been written returns a fixed fill word whose encoding traps as undefined.

Top module: `lanemem_xfer`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_valid` and `done` are 0.
- R2: A word write (`req_kind`=1, `req_size`=2) with `req_cp`=0 stores `req_wdata` at word index `req_addr[31:2]` and ignores the slots. A read (`req_kind`=0) with `req_cp`=0 returns exactly one word: the word stored at that index.
- R3: A byte write (`req_size`=0) with `req_cp`=0 replaces only one lane with `req_wdata[7:0]`. Address bits [1:0] = 0, 1, 2, 3 select stored bits [7:0], [15:8], [23:16], [31:24].
- R4: A halfword write (`req_size`=1) with `req_cp`=0 replaces bits [31:16] when address bit 1 is set, and bits [15:0] when it is clear, with `req_wdata[15:0]`.
- R5: A word that has never been written reads as 0xE6000010, including as the base of a lane merge.
- R6: A write with `req_cp`=1 stores the leading run of full slots (`slot_full[i]`=1, data `slot_data[32*i+31:32*i]`, from slot 0 upward) as whole words at consecutive word indices from the request address. It emits no read data.
- R7: A read with `req_cp`=1 emits as many consecutive words as there are leading empty slots, starting at the request address. With slot 0 full, it emits none.
- R8: A coprocessor word write (`req_kind`=2) emits `req_wdata` as one stream word when `req_cp`=1, and emits nothing when `req_cp`=0.
- R9: A slot flush (`req_kind`=3) with `req_cp`=1 emits the data of the leading full slots in slot order. With `req_cp`=0 it emits nothing.
- R10: Each request ends with a `done` pulse one cycle long, followed by `req_ready`. A non-coprocessor word write takes 2 cycles from acceptance to `done`. A byte or halfword write takes 3 cycles: read, merge-write, done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_kind | input | 2 | 0 read, 1 write, 2 coprocessor word write, 3 slot flush |
| req_size | input | 2 | Write size: 0 byte, 1 halfword, 2 word |
| req_cp | input | 1 | Coprocessor-mode flag |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data or coprocessor word |
| slot_full | input | NSLOT | Per-slot full flag from the dispatch unit |
| slot_data | input | 32*NSLOT | Slot words, slot i in bits [32i+31:32i] |
| req_ready | output | 1 | Sequencer idle, a request can be taken |
| rd_valid | output | 1 | Read-stream word valid this cycle |
| rd_data | output | 32 | Read-stream word |
| done | output | 1 | Request finished |

## Verification
The assertions assume that a request is offered only while `req_ready` is high. They also assume that the slot flags and data are stable in the cycle of acceptance, because the sequencer captures them at that edge. The stimulus waits for `req_ready` and then presents every field for one clock, then drops `req_valid`. It never offers a new request before the previous `done` has been seen. Addresses stay inside the default memory depth, so the upper address bits, which are ignored, play no part.

// File: rtl/lanemem_pkg.sv
package lanemem_pkg;

    typedef enum logic [1:0] {
        XK_READ  = 2'd0,
        XK_WRITE = 2'd1,
        XK_COPWR = 2'd2,
        XK_SLOTS = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        XS_BYTE = 2'd0,
        XS_HALF = 2'd1,
        XS_WORD = 2'd2,
        XS_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_EMIT,
        ST_WR_BEAT,
        ST_MRG_RD,
        ST_MRG_WR,
        ST_EMIT,
        ST_DONE
    } seq_state_e;

    localparam logic [31:0] FILL_WORD = 32'hE600_0010;

    // Place the new byte or halfword into the selected lanes of the old word.
    function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                                input logic [31:0] new_w,
                                                input xfer_size_e  size,
                                                input logic [1:0]  lane);
        logic [31:0] r;
        r = old_w;
        case (size)
            XS_BYTE: r[8*lane +: 8] = new_w[7:0];
            XS_HALF: begin
                if (lane[1]) r[31:16] = new_w[15:0];
                else         r[15:0]  = new_w[15:0];
            end
            default: r = new_w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lanemem_runlen.sv
module lanemem_runlen #(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic [N-1:0]  bits,
    input  logic          target,
    output logic [CW-1:0] count
);
    // alive[i+1] is set while slots 0..i all equal target
    logic [N:0] alive;
    assign alive[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign alive[i+1] = alive[i] & (bits[i] == target);
    end

    assign count = CW'($countones(alive[N:1]));
endmodule

// File: rtl/lanemem_store.sv
module lanemem_store
    import lanemem_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [31:0]   wd,
    output logic [31:0]   q
);
    logic [31:0]      mem [DEPTH];
    logic [DEPTH-1:0] written;

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            written <= '0;
            q       <= '0;
        end else begin
            if (we) written[idx] <= 1'b1;
            if (re) q <= written[idx] ? mem[idx] : FILL_WORD;
        end
    end
endmodule

// File: rtl/lanemem_seq.sv
module lanemem_seq
    import lanemem_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int AW    = 6,
    parameter int CW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  xfer_kind_e        req_kind,
    input  xfer_size_e        req_size,
    input  logic              req_cp,
    input  logic [AW-1:0]     req_idx,
    input  logic [1:0]        req_lane,
    input  logic [31:0]       req_wdata,
    input  logic [32*NSLOT-1:0] slot_data,
    input  logic [CW-1:0]     empty_run,
    input  logic [CW-1:0]     full_run,
    input  logic [31:0]       mem_q,
    output logic              mem_re,
    output logic              mem_we,
    output logic [AW-1:0]     mem_idx,
    output logic [31:0]       mem_wd,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              done
);
    seq_state_e          st_q;
    xfer_kind_e          kind_q;
    xfer_size_e          size_q;
    logic                cp_q;
    logic [AW-1:0]       base_q;
    logic [1:0]          lane_q;
    logic [31:0]         wdata_q;
    logic [32*NSLOT-1:0] slots_q;
    logic [CW-1:0]       beat_q;
    logic [CW-1:0]       n_q;
    logic [CW-1:0]       beat_nx;
    logic                last_beat;
    logic [31:0]         slot_cur;

    assign beat_nx   = beat_q + CW'(1);
    assign last_beat = (beat_nx == n_q);
    assign slot_cur  = slots_q[32*beat_q +: 32];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            kind_q  <= XK_READ;
            size_q  <= XS_WORD;
            cp_q    <= 1'b0;
            base_q  <= '0;
            lane_q  <= '0;
            wdata_q <= '0;
            slots_q <= '0;
            beat_q  <= '0;
            n_q     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    kind_q  <= req_kind;
                    size_q  <= req_size;
                    cp_q    <= req_cp;
                    base_q  <= req_idx;
                    lane_q  <= req_lane;
                    wdata_q <= req_wdata;
                    slots_q <= slot_data;
                    beat_q  <= '0;
                    case (req_kind)
                        XK_READ: begin
                            n_q  <= req_cp ? empty_run : CW'(1);
                            st_q <= (req_cp && empty_run == '0) ? ST_DONE : ST_RD_ISSUE;
                        end
                        XK_WRITE: begin
                            if (req_cp) begin
                                n_q  <= full_run;
                                st_q <= (full_run == '0) ? ST_DONE : ST_WR_BEAT;
                            end else begin
                                n_q  <= CW'(1);
                                st_q <= (req_size == XS_BYTE || req_size == XS_HALF)
                                        ? ST_MRG_RD : ST_WR_BEAT;
                            end
                        end
                        XK_COPWR: begin
                            n_q  <= CW'(1);
                            st_q <= req_cp ? ST_EMIT : ST_DONE;
                        end
                        default: begin
                            n_q  <= full_run;
                            st_q <= (req_cp && full_run != '0) ? ST_EMIT : ST_DONE;
                        end
                    endcase
                end
                ST_RD_ISSUE: st_q <= ST_RD_EMIT;
                ST_RD_EMIT: begin
                    beat_q <= beat_nx;
                    st_q   <= last_beat ? ST_DONE : ST_RD_ISSUE;
                end
                ST_WR_BEAT: begin
                    beat_q <= beat_nx;
                    st_q   <= last_beat ? ST_DONE : ST_WR_BEAT;
                end
                ST_EMIT: begin
                    beat_q <= beat_nx;
                    st_q   <= last_beat ? ST_DONE : ST_EMIT;
                end
                ST_MRG_RD: st_q <= ST_MRG_WR;
                ST_MRG_WR: st_q <= ST_DONE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (st_q == ST_IDLE);
        done      = (st_q == ST_DONE);
        mem_idx   = base_q + AW'(beat_q);
        mem_re    = (st_q == ST_RD_ISSUE) || (st_q == ST_MRG_RD);
        mem_we    = (st_q == ST_WR_BEAT) || (st_q == ST_MRG_WR);
        if (st_q == ST_MRG_WR) mem_wd = merge_lanes(mem_q, wdata_q, size_q, lane_q);
        else if (cp_q)         mem_wd = slot_cur;
        else                   mem_wd = wdata_q;
        rd_valid  = (st_q == ST_RD_EMIT) || (st_q == ST_EMIT);
        if (st_q == ST_RD_EMIT)       rd_data = mem_q;
        else if (kind_q == XK_COPWR)  rd_data = wdata_q;
        else                          rd_data = slot_cur;
    end
endmodule

// File: rtl/lanemem_xfer.sv
module lanemem_xfer
    import lanemem_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NSLOT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [1:0]          req_size,
    input  logic                req_cp,
    input  logic [31:0]         req_addr,
    input  logic [31:0]         req_wdata,
    input  logic [NSLOT-1:0]    slot_full,
    input  logic [32*NSLOT-1:0] slot_data,
    output logic                req_ready,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    output logic                done
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(NSLOT + 1);

    logic [CW-1:0] empty_run;
    logic [CW-1:0] full_run;
    logic          mem_re;
    logic          mem_we;
    logic [AW-1:0] mem_idx;
    logic [31:0]   mem_wd;
    logic [31:0]   mem_q;
    logic          unused_addr_hi;

    assign unused_addr_hi = ^req_addr[31:AW+2];

    lanemem_runlen #(.N(NSLOT), .CW(CW)) u_empty_run (
        .bits(slot_full), .target(1'b0), .count(empty_run)
    );

    lanemem_runlen #(.N(NSLOT), .CW(CW)) u_full_run (
        .bits(slot_full), .target(1'b1), .count(full_run)
    );

    lanemem_seq #(.NSLOT(NSLOT), .AW(AW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (xfer_kind_e'(req_kind)),
        .req_size  (xfer_size_e'(req_size)),
        .req_cp    (req_cp),
        .req_idx   (req_addr[AW+1:2]),
        .req_lane  (req_addr[1:0]),
        .req_wdata (req_wdata),
        .slot_data (slot_data),
        .empty_run (empty_run),
        .full_run  (full_run),
        .mem_q     (mem_q),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_wd    (mem_wd),
        .req_ready (req_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .done      (done)
    );

    lanemem_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk (clk),
        .rst (rst),
        .re  (mem_re),
        .we  (mem_we),
        .idx (mem_idx),
        .wd  (mem_wd),
        .q   (mem_q)
    );
endmodule

// File: rtl/lanemem_checker.sv
module lanemem_checker #(
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             req_cp,
    input logic [NSLOT-1:0] slot_full,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             done
);
    logic accept;
    assign accept = req_valid && req_ready;

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    a_r10_no_stream_when_idle: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !req_ready);

    a_r2_read_has_latency: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == 2'd0 && !req_cp) |=> (!rd_valid && !req_ready && !done));

    a_r7_full_head_no_words: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == 2'd0 && req_cp && slot_full[0]) |=> (done && !rd_valid));

    a_r8_plain_copwr_silent: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == 2'd2 && !req_cp) |=> (done && !rd_valid));

    a_r9_plain_flush_silent: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == 2'd3 && !req_cp) |=> (done && !rd_valid));
endmodule

bind lanemem_xfer lanemem_checker #(.NSLOT(NSLOT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_cp    (req_cp),
    .slot_full (slot_full),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .done      (done)
);

// File: tb/lanemem_xfer_bench.sv
module lanemem_xfer_bench;
    localparam int NSLOT = 4;
    localparam logic [31:0] FILL = 32'hE600_0010;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic [1:0]          req_kind = '0;
    logic [1:0]          req_size = '0;
    logic                req_cp = 1'b0;
    logic [31:0]         req_addr = '0;
    logic [31:0]         req_wdata = '0;
    logic [NSLOT-1:0]    slot_full = '0;
    logic [32*NSLOT-1:0] slot_data = '0;
    logic                req_ready;
    logic                rd_valid;
    logic [31:0]         rd_data;
    logic                done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] got [8];
    int got_n;
    int lat;

    always #10 clk = ~clk;

    lanemem_xfer #(.DEPTH(64), .NSLOT(NSLOT)) u_lanemem_xfer (
        .clk, .rst, .req_valid, .req_kind, .req_size, .req_cp, .req_addr,
        .req_wdata, .slot_full, .slot_data, .req_ready, .rd_valid, .rd_data, .done
    );

    // {size, addr, wdata, expected word after the write}
    localparam logic [97:0] TBL [10] = '{
        {2'd2, 32'h10, 32'h1122_3344, 32'h1122_3344},
        {2'd0, 32'h10, 32'h0000_00AA, 32'h1122_33AA},
        {2'd0, 32'h11, 32'h0000_00BB, 32'h1122_BBAA},
        {2'd0, 32'h12, 32'h0000_00CC, 32'h11CC_BBAA},
        {2'd0, 32'h13, 32'hFFFF_FFDD, 32'hDDCC_BBAA},
        {2'd1, 32'h12, 32'h0000_5566, 32'h5566_BBAA},
        {2'd1, 32'h10, 32'hABCD_7788, 32'h5566_7788},
        {2'd0, 32'h20, 32'h0000_0099, 32'hE600_0099},
        {2'd1, 32'h26, 32'h0000_1234, 32'h1234_0010},
        {2'd2, 32'h2C, 32'hCAFE_F00D, 32'hCAFE_F00D}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] kind, input logic [1:0] size,
                           input logic cp, input logic [31:0] addr,
                           input logic [31:0] wdata, input logic [NSLOT-1:0] full,
                           input logic [32*NSLOT-1:0] sdata);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_size = size; req_cp = cp;
        req_addr = addr; req_wdata = wdata; slot_full = full; slot_data = sdata;
        got_n = 0; lat = 0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 60; k++) begin
            lat++;
            if (rd_valid && got_n < 8) begin
                got[got_n] = rd_data;
                got_n++;
            end
            if (done) break;
            if (k == 59) begin
                checks++; errors++;
                $display("FAIL R10: request timeout actual no done expected done");
            end
            @(negedge clk);
        end
    endtask

    task automatic read_word(input logic [31:0] addr, input string tag, input logic [31:0] exp);
        run_req(2'd0, 2'd2, 1'b0, addr, 32'h0, '0, '0);
        chk({tag, " word count"}, 32'(got_n), 32'd1);
        chk(tag, got[0], exp);
    endtask

    localparam logic [32*NSLOT-1:0] SLOTS =
        {32'hA300_0003, 32'hA200_0002, 32'hA100_0001, 32'hA000_0000};

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        rst = 1'b0;

        // R5: untouched word
        read_word(32'h40, "R5 fill", FILL);

        // Table walk: R2 word, R3 byte, R4 half, R10 latency
        for (int i = 0; i < 10; i++) begin
            logic [1:0]  sz;
            logic [31:0] ad;
            sz = TBL[i][97:96];
            ad = TBL[i][95:64];
            run_req(2'd1, sz, 1'b0, ad, TBL[i][63:32], '0, '0);
            chk("R10 write latency", 32'(lat), (sz == 2'd2) ? 32'd2 : 32'd3);
            chk("R10 no stream on write", 32'(got_n), 32'd0);
            read_word({ad[31:2], 2'b00},
                      (sz == 2'd0) ? "R3 byte lane" : (sz == 2'd1) ? "R4 half lane" : "R2 word",
                      TBL[i][31:0]);
        end

        // R2: plain word write ignores slots
        run_req(2'd1, 2'd2, 1'b0, 32'h90, 32'h0BAD_CAFE, 4'b1111, SLOTS);
        read_word(32'h90, "R2 plain write", 32'h0BAD_CAFE);
        read_word(32'h94, "R2 slots ignored", FILL);

        // R6: coprocessor write burst of leading full slots
        run_req(2'd1, 2'd2, 1'b1, 32'h80, 32'h0, 4'b0111, SLOTS);
        chk("R6 no stream", 32'(got_n), 32'd0);
        read_word(32'h80, "R6 beat0", 32'hA000_0000);
        read_word(32'h84, "R6 beat1", 32'hA100_0001);
        read_word(32'h88, "R6 beat2", 32'hA200_0002);
        read_word(32'h8C, "R6 stop at first empty", FILL);

        // R7: coprocessor read bursts
        run_req(2'd0, 2'd2, 1'b1, 32'h80, 32'h0, 4'b1000, SLOTS);
        chk("R7 count three", 32'(got_n), 32'd3);
        chk("R7 w0", got[0], 32'hA000_0000);
        chk("R7 w1", got[1], 32'hA100_0001);
        chk("R7 w2", got[2], 32'hA200_0002);
        run_req(2'd0, 2'd2, 1'b1, 32'h84, 32'h0, 4'b0000, SLOTS);
        chk("R7 count all empty", 32'(got_n), 32'd4);
        chk("R7 a0", got[0], 32'hA100_0001);
        chk("R7 a1", got[1], 32'hA200_0002);
        chk("R7 a2", got[2], FILL);
        chk("R7 a3", got[3], 32'h0BAD_CAFE);
        run_req(2'd0, 2'd2, 1'b1, 32'h80, 32'h0, 4'b0101, SLOTS);
        chk("R7 full head none", 32'(got_n), 32'd0);

        // R8: coprocessor word write
        run_req(2'd2, 2'd2, 1'b1, 32'h0, 32'h1357_9BDF, '0, '0);
        chk("R8 cp count", 32'(got_n), 32'd1);
        chk("R8 cp word", got[0], 32'h1357_9BDF);
        run_req(2'd2, 2'd2, 1'b0, 32'h0, 32'h1357_9BDF, '0, '0);
        chk("R8 plain ignored", 32'(got_n), 32'd0);

        // R9: slot flush
        run_req(2'd3, 2'd2, 1'b1, 32'h0, 32'h0, 4'b1011, SLOTS);
        chk("R9 cp count", 32'(got_n), 32'd2);
        chk("R9 s0", got[0], 32'hA000_0000);
        chk("R9 s1", got[1], 32'hA100_0001);
        run_req(2'd3, 2'd2, 1'b0, 32'h0, 32'h0, 4'b1111, SLOTS);
        chk("R9 plain ignored", 32'(got_n), 32'd0);
        run_req(2'd3, 2'd2, 1'b1, 32'h0, 32'h0, 4'b0000, SLOTS);
        chk("R9 empty head none", 32'(got_n), 32'd0);

        @(negedge clk);
        chk("R10 idle after done", 32'(req_ready), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule